// File: doc/BRIEF.md
# Indexed Bit-Operation Sequencer

This block takes an instruction byte stream, one byte per cycle in which `in_valid` is high, and picks out four-byte indexed bit operations. Such a sequence names one of two 16-bit base registers, a signed offset, and an operation on one byte of memory. The block adds the offset to the chosen base and reads that byte through a request/acknowledge port. It then rotates or shifts the byte, tests one of its bits, clears a bit, or sets a bit. Every kind of operation except the test writes the new byte back to the same address.

A modifying operation can also copy the byte it writes back into one of the eight-bit working registers. The low three bits of the operation byte name that register. The pattern 110 means "memory only". The two base register values and the incoming carry come from the surrounding core as plain inputs. The block reports the register write, the zero and carry flags and the memory traffic on its own output ports.

Top module: `idx_bitop_seq`

## Requirements
- R1: While reset is asserted and after it is released, `mem_req`, `reg_we` and `flag_we` are low until a complete sequence has been taken in.
- R2: A sequence consists of a prefix byte (0xDD uses base `ix_base`, 0xFD uses `iy_base`), then 0xCB, then the offset byte, then the operation byte. Each byte is taken only in a cycle with `in_valid` high. A byte other than 0xCB right after a prefix abandons the sequence. Bytes that arrive while a memory access or an execution is in progress are ignored.
- R3: The address is the selected base plus the sign-extended offset, modulo 2^16.
- R4: A read (`mem_req`=1, `mem_we`=0) is issued after the operation byte. It holds its address until `mem_ack`, and `mem_rdata` is taken in the ack cycle.
- R5: Class 00 (operation bits 7:6) shifts the byte by kind, bits 5:3: 000 rotate left circular, 001 rotate right circular, 010 rotate left through carry, 011 rotate right through carry, 100 shift left arithmetic, 101 shift right arithmetic, 110 shift left with bit 0 forced to 1, 111 shift right logical. The carry out is the bit shifted out.
- R6: Class 01 tests bit number bits 5:3. It sets `flag_z` when that bit is 0, passes `carry_in` to `flag_c`, and writes neither memory nor a register, whatever bits 2:0 hold.
- R7: Class 10 clears and class 11 sets the bit numbered by bits 5:3. All other bits are kept.
- R8: Classes 00, 10 and 11 write the result back to the read address with `mem_we`=1. The request holds its address and data until `mem_ack`.
- R9: For classes 00, 10 and 11 with bits 2:0 not 110, `reg_we` pulses for one cycle, in the ack cycle of the write-back. `reg_sel` then carries bits 2:0 (B=000, C=001, D=010, E=011, H=100, L=101, A=111) and `reg_data` carries the same byte as the memory write. Code 110 writes no register.
- R10: In the cycle after the read ack, `flag_we` pulses for one cycle for classes 00 and 01, with `flag_z` and `flag_c`. For class 00, `flag_z` is set when the result is zero. Classes 10 and 11 raise no flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| ix_base | input | 16 | Base register chosen by prefix 0xDD |
| iy_base | input | 16 | Base register chosen by prefix 0xFD |
| carry_in | input | 1 | Current carry flag of the core |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write-back byte |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_sel | output | 3 | Destination register code |
| reg_data | output | 8 | Byte copied to the register |
| flag_we | output | 1 | One-cycle flag update strobe |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |

## Verification
The bench builds the block with the default 16-bit address width. The address sum therefore wraps at both ends: a base of 0xFFFF with a positive offset, and a base of 0x0000 with offset 0x80. Base values and offsets near those edges reach the modulo behaviour with a few sequences. The memory responder's latency is varied, so that bytes arriving during a stretched read can be shown to have no effect.

// File: rtl/idxbit_pkg.sv
package idxbit_pkg;
    localparam int           BYTE_W   = 8;
    localparam logic [7:0]   PFX_X    = 8'hDD;
    localparam logic [7:0]   PFX_Y    = 8'hFD;
    localparam logic [7:0]   GRP_BYTE = 8'hCB;
    localparam logic [2:0]   NO_REG   = 3'b110;

    typedef enum logic [2:0] {
        S_IDLE, S_PFX, S_GRP, S_DISP, S_READ, S_EXEC, S_WRITE
    } seq_state_e;

    typedef enum logic [1:0] {
        C_SHIFT = 2'b00,
        C_TEST  = 2'b01,
        C_CLR   = 2'b10,
        C_SET   = 2'b11
    } op_class_e;
endpackage

// File: rtl/idxbit_agen.sv
module idxbit_agen #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] disp_ext;

    generate
        if (ADDR_W > DISP_W) begin : g_extend
            assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
        end else begin : g_trunc
            assign disp_ext = disp_i[ADDR_W-1:0];
        end
    endgenerate

    assign addr_o = base_i + disp_ext;
endmodule

// File: rtl/idxbit_alu.sv
module idxbit_alu
    import idxbit_pkg::*;
(
    input  logic [7:0]        op_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic              cin_i,
    output logic [BYTE_W-1:0] res_o,
    output logic              cout_o,
    output logic              zero_o
);
    logic [BYTE_W-1:0] mask;
    op_class_e         cls;
    logic [2:0]        kind;

    assign cls  = op_class_e'(op_i[7:6]);
    assign kind = op_i[5:3];

    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
        assign mask[i] = (kind == 3'(i));
    end

    always_comb begin
        res_o  = din_i;
        cout_o = cin_i;
        unique case (cls)
            C_SHIFT: begin
                unique case (kind)
                    3'd0: begin res_o = {din_i[6:0], din_i[7]}; cout_o = din_i[7]; end
                    3'd1: begin res_o = {din_i[0], din_i[7:1]}; cout_o = din_i[0]; end
                    3'd2: begin res_o = {din_i[6:0], cin_i};    cout_o = din_i[7]; end
                    3'd3: begin res_o = {cin_i, din_i[7:1]};    cout_o = din_i[0]; end
                    3'd4: begin res_o = {din_i[6:0], 1'b0};     cout_o = din_i[7]; end
                    3'd5: begin res_o = {din_i[7], din_i[7:1]}; cout_o = din_i[0]; end
                    3'd6: begin res_o = {din_i[6:0], 1'b1};     cout_o = din_i[7]; end
                    default: begin res_o = {1'b0, din_i[7:1]};  cout_o = din_i[0]; end
                endcase
            end
            C_TEST:  res_o = din_i;
            C_CLR:   res_o = din_i & ~mask;
            default: res_o = din_i | mask;
        endcase
        zero_o = (cls == C_TEST) ? ~|(din_i & mask) : ~|res_o;
    end
endmodule

// File: rtl/idx_bitop_seq.sv
module idx_bitop_seq
    import idxbit_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic [ADDR_W-1:0] ix_base,
    input  logic [ADDR_W-1:0] iy_base,
    input  logic              carry_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              reg_we,
    output logic [2:0]        reg_sel,
    output logic [7:0]        reg_data,
    output logic              flag_we,
    output logic              flag_z,
    output logic              flag_c
);
    typedef struct packed {
        seq_state_e        state;
        logic              use_y;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        op;
        logic [7:0]        data;
    } seq_regs_t;

    seq_regs_t         st_d, st_q;
    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] eff_addr;
    logic [7:0]        alu_res;
    logic              alu_cout;
    logic              alu_zero;
    op_class_e         cls_q;

    assign base_sel = st_q.use_y ? iy_base : ix_base;
    assign cls_q    = op_class_e'(st_q.op[7:6]);

    idxbit_agen #(.ADDR_W(ADDR_W), .DISP_W(8)) i_agen (
        .base_i (base_sel),
        .disp_i (in_byte),
        .addr_o (eff_addr)
    );

    idxbit_alu i_alu (
        .op_i   (st_q.op),
        .din_i  (st_q.data),
        .cin_i  (carry_in),
        .res_o  (alu_res),
        .cout_o (alu_cout),
        .zero_o (alu_zero)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            S_IDLE: begin
                if (in_valid && (in_byte == PFX_X || in_byte == PFX_Y)) begin
                    st_d.use_y = (in_byte == PFX_Y);
                    st_d.state = S_PFX;
                end
            end
            S_PFX: begin
                if (in_valid) begin
                    st_d.state = (in_byte == GRP_BYTE) ? S_GRP : S_IDLE;
                end
            end
            S_GRP: begin
                if (in_valid) begin
                    st_d.addr  = eff_addr;
                    st_d.state = S_DISP;
                end
            end
            S_DISP: begin
                if (in_valid) begin
                    st_d.op    = in_byte;
                    st_d.state = S_READ;
                end
            end
            S_READ: begin
                if (mem_ack) begin
                    st_d.data  = mem_rdata;
                    st_d.state = S_EXEC;
                end
            end
            S_EXEC: begin
                st_d.data  = alu_res;
                st_d.state = (cls_q == C_TEST) ? S_IDLE : S_WRITE;
            end
            S_WRITE: begin
                if (mem_ack) begin
                    st_d.state = S_IDLE;
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: S_IDLE, use_y: 1'b0, addr: '0, op: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req   = (st_q.state == S_READ) || (st_q.state == S_WRITE);
    assign mem_we    = (st_q.state == S_WRITE);
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.data;

    assign reg_we    = (st_q.state == S_WRITE) && mem_ack && (st_q.op[2:0] != NO_REG);
    assign reg_sel   = st_q.op[2:0];
    assign reg_data  = st_q.data;

    assign flag_we   = (st_q.state == S_EXEC) && (cls_q == C_SHIFT || cls_q == C_TEST);
    assign flag_z    = alu_zero;
    assign flag_c    = alu_cout;
endmodule

// File: rtl/idxbit_seq_chk.sv
module idxbit_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic              flag_we
);
    // R4: an access stays put until it is acknowledged
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: write data held and write only inside a request
    assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

    assert_we_in_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R9: register copy only with the acknowledged write-back, never code 110
    assert_reg_with_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (mem_req && mem_we && mem_ack && reg_sel != 3'b110));

    assert_reg_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R10: flag strobe is one cycle and follows a completed read
    assert_flag_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> !flag_we);

    assert_flag_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> $past(mem_req && !mem_we && mem_ack));
endmodule

bind idx_bitop_seq idxbit_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .flag_we   (flag_we)
);

// File: tb/test_idx_bitop_seq.sv
`timescale 1ns/1ps
module test_idx_bitop_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [15:0] ix_base = 16'h0000;
    logic [15:0] iy_base = 16'h0000;
    logic        carry_in = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_data;
    logic        flag_we, flag_z, flag_c;

    always #4 clk = ~clk;

    idx_bitop_seq i_idx_bitop_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .ix_base(ix_base), .iy_base(iy_base), .carry_in(carry_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_data(reg_data),
        .flag_we(flag_we), .flag_z(flag_z), .flag_c(flag_c)
    );

    localparam int K_RD = 0, K_FLAG = 1, K_MW = 2, K_RW = 3;
    typedef struct {
        int    kind;
        int    a;
        int    d;
        string tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] mem [int];
    int         checks = 0;
    int         fails = 0;
    int         lat = 0;
    int         gap = 0;
    bit         extra = 1'b0;
    int         wcnt = 0;

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic pop_cmp(int kind, int a, int d);
        exp_t e;
        if (sb.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R2 unexpected event actual=%0d expected=none", kind);
        end else begin
            e = sb.pop_front();
            check(e.tag, "kind", kind, e.kind);
            check(e.tag, "addr/sel", a, e.a);
            check(e.tag, "data", d, e.d);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                if (!mem_we)
                    mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
            end else begin
                wcnt++;
            end
        end
    end

    // monitor
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (mem_req && mem_ack && !mem_we) pop_cmp(K_RD, int'(mem_addr), 0);
            if (flag_we) pop_cmp(K_FLAG, 0, int'({flag_z, flag_c}));
            if (mem_req && mem_we && mem_ack) begin
                pop_cmp(K_MW, int'(mem_addr), int'(mem_wdata));
                mem[int'(mem_addr)] = mem_wdata;
            end
            if (reg_we) pop_cmp(K_RW, int'(reg_sel), int'(reg_data));
        end
    end

    function automatic void model(input logic [7:0] op, input logic [7:0] din, input logic cin,
                                  output logic [7:0] res, output logic cout);
        logic [7:0] bm;
        bm = 8'h01 << op[5:3];
        res = din;
        cout = cin;
        case (op[7:6])
            2'b00: case (op[5:3])
                3'd0: begin res = {din[6:0], din[7]}; cout = din[7]; end
                3'd1: begin res = {din[0], din[7:1]}; cout = din[0]; end
                3'd2: begin res = {din[6:0], cin};    cout = din[7]; end
                3'd3: begin res = {cin, din[7:1]};    cout = din[0]; end
                3'd4: begin res = {din[6:0], 1'b0};   cout = din[7]; end
                3'd5: begin res = {din[7], din[7:1]}; cout = din[0]; end
                3'd6: begin res = {din[6:0], 1'b1};   cout = din[7]; end
                default: begin res = {1'b0, din[7:1]}; cout = din[0]; end
            endcase
            2'b10: res = din & ~bm;
            2'b11: res = din | bm;
            default: res = din;
        endcase
    endfunction

    task automatic push(int kind, int a, int d, string tag);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic send_byte(logic [7:0] b);
        in_valid = 1'b1;
        in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte = 8'hCB;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
        check(tag, "pending items", sb.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_op(string tag, logic [7:0] pfx, logic [7:0] disp, logic [7:0] op,
                          logic [7:0] din, logic cin);
        logic [15:0] base, addr;
        logic [7:0]  res;
        logic        cout;
        base = (pfx == 8'hDD) ? ix_base : iy_base;
        addr = base + {{8{disp[7]}}, disp};
        mem[int'(addr)] = din;
        carry_in = cin;
        model(op, din, cin, res, cout);
        push(K_RD, int'(addr), 0, tag);
        if (op[7:6] == 2'b00) push(K_FLAG, 0, int'({res == 8'h00, cout}), tag);
        if (op[7:6] == 2'b01) push(K_FLAG, 0, int'({~din[op[5:3]], cin}), tag);
        if (op[7:6] != 2'b01) begin
            push(K_MW, int'(addr), int'(res), tag);
            if (op[2:0] != 3'b110) push(K_RW, int'(op[2:0]), int'(res), tag);
        end
        send_byte(pfx);
        send_byte(8'hCB);
        send_byte(disp);
        send_byte(op);
        if (extra) begin
            send_byte(8'hDD);
            send_byte(8'hCB);
            send_byte(8'h10);
        end
        drain(tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "mem_req in reset", int'(mem_req), 0);
        check("R1", "reg_we in reset", int'(reg_we), 0);
        check("R1", "flag_we in reset", int'(flag_we), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "mem_req idle", int'(mem_req), 0);
        check("R1", "flag_we idle", int'(flag_we), 0);

        ix_base = 16'h1000;
        iy_base = 16'h2001;
        run_op("R5 R3 R9 rlc to B", 8'hDD, 8'h05, 8'h00, 8'h81, 1'b0);
        run_op("R5 R3 R9 rr to A neg offset", 8'hFD, 8'hFE, 8'h1F, 8'h01, 1'b1);
        run_op("R5 rl to C", 8'hDD, 8'h10, 8'h11, 8'h80, 1'b0);
        run_op("R5 rrc to L", 8'hFD, 8'h00, 8'h0D, 8'h01, 1'b0);
        run_op("R5 R10 sla to D zero", 8'hDD, 8'h7F, 8'h22, 8'h80, 1'b0);
        run_op("R5 R10 srl to E zero", 8'hFD, 8'h03, 8'h3B, 8'h01, 1'b0);

        ix_base = 16'hFFFF;
        iy_base = 16'h0000;
        run_op("R3 R8 wrap up sll mem only", 8'hDD, 8'h02, 8'h36, 8'h40, 1'b0);
        run_op("R3 R5 wrap down sra to L", 8'hFD, 8'h80, 8'h2D, 8'h80, 1'b1);

        ix_base = 16'h4000;
        iy_base = 16'h8000;
        run_op("R6 R10 test bit0 zero", 8'hDD, 8'h01, 8'h46, 8'hFE, 1'b1);
        run_op("R6 test bit7 reg code A ignored", 8'hFD, 8'h02, 8'h7F, 8'h80, 1'b0);
        run_op("R7 R9 clear bit0 to A", 8'hDD, 8'h03, 8'h87, 8'hFF, 1'b0);
        run_op("R7 R8 set bit7 mem only", 8'hFD, 8'h04, 8'hFE, 8'h00, 1'b1);
        run_op("R7 R9 set bit0 to H", 8'hDD, 8'h05, 8'hC4, 8'h12, 1'b0);

        // R2: a non-group byte after the prefix abandons the sequence
        send_byte(8'hDD);
        send_byte(8'h00);
        run_op("R2 after abort", 8'hDD, 8'h06, 8'h1A, 8'h55, 1'b1);

        // R2 R4: stretched accesses, bytes during the read ignored, gaps between bytes
        lat = 4;
        extra = 1'b1;
        run_op("R2 R4 busy bytes ignored", 8'hFD, 8'h07, 8'h03, 8'hC3, 1'b0);
        extra = 1'b0;
        gap = 2;
        run_op("R2 R4 gapped stream", 8'hDD, 8'hF0, 8'hA9, 8'hFF, 1'b0);
        gap = 0;
        lat = 1;
        run_op("R6 R4 test with wait", 8'hFD, 8'h08, 8'h5E, 8'h08, 1'b1);

        check("R2", "leftover items", sb.size(), 0);
        summary();
        $finish;
    end
endmodule